// File: doc/BRIEF.md
# Time-Base and Watchdog Interrupt Generator

This block is driven by a slow clock-enable tick of roughly 32 kHz. The tick feeds one shared binary divider. The low bits of the divider form a divide-by-256 prescaler. The upper bits split the prescaled rate further. A 3-bit rate code picks one of eight time-base frequencies, from 1 Hz up to 128 Hz. A watchdog counts complete time-base periods. When four periods pass without a watchdog clear, it raises a time-out flag.

A command decoder drives the control inputs with single-cycle pulses:
- enable and disable for the timer;
- enable, disable and clear for the watchdog;
- enable and disable for the interrupt;
- clear for the timer.

The active-low `irq_n` level is meant for an open-drain pin. When the interrupt is enabled, `irq_n` follows two sources: the low phase of the time-base square wave while the timer is on, and the latched watchdog flag. The flag holds the line low until software clears the watchdog or disables the interrupt.

Top module: `tbwd_gen`

## Requirements
- R1: Out of reset the timer, watchdog and interrupt are all disabled, the divider is zero, and `irq_n` is 1. No tick pattern moves `irq_n` until an enable pulse arrives.
- R2: The divider advances by exactly one on each cycle with `tick_en` high. It holds its value when `tick_en` is low.
- R3: Rate code k (0..7) gives a time-base square wave of 2^(15-k) ticks per period (1 Hz · 2^k at a 32768 Hz tick). Following a timer clear, the wave is low for the first half-period and high for the second.
- R4: A timer-clear pulse zeroes the whole divider on the next edge and overrides a coincident tick, so that a full period follows.
- R5: When the watchdog is enabled, it counts completed time-base periods in a 2-bit counter. Its flag sets on the tick that completes the fourth period.
- R6: Once set, the watchdog flag holds `irq_n` low (with the interrupt enabled) until a watchdog-clear, watchdog-disable or interrupt-disable pulse. A watchdog clear also restarts the period count.
- R7: `irq_n` is 1 whenever the interrupt is disabled. An interrupt-disable pulse also discards a pending watchdog flag.
- R8: With the interrupt enabled, `irq_n` is 0 exactly when the timer is on and the time-base wave is low, or when the watchdog flag is set.
- R9: When an enable and a disable pulse for the same function arrive in one cycle, the disable wins.
- R10: The controls act independently of each other. A timer clear does not clear the watchdog flag. A watchdog clear does not disturb the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle tick of the ~32 kHz time source |
| tmr_en | input | 1 | Pulse: switch time-base output on |
| tmr_dis | input | 1 | Pulse: switch time-base output off |
| tmr_clr | input | 1 | Pulse: zero the shared divider |
| wdt_en | input | 1 | Pulse: start watchdog period counting |
| wdt_dis | input | 1 | Pulse: stop the watchdog, drop count and flag |
| wdt_clr | input | 1 | Pulse: zero the watchdog count and flag |
| irq_en | input | 1 | Pulse: let the sources reach `irq_n` |
| irq_dis | input | 1 | Pulse: block `irq_n`, drop watchdog flag |
| rate_sel | input | 3 | Time-base rate code, k selects 2^k Hz |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The properties assume that every control input is a clean synchronous level sampled at the clock edge. They also assume that `rate_sel` is a plain code that may change in any cycle; nothing expects it to be held steady. The properties place no rule on how often pulses come or how they overlap. The random stimulus therefore fires each pulse independently, lets enable/disable pairs collide, and drops ticks at random. Clears are kept rare enough that the watchdog still reaches its fourth period at the faster rates.

// File: rtl/tbwd_gen.sv
module tbwd_gen #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              tmr_en,
  input  logic              tmr_dis,
  input  logic              tmr_clr,
  input  logic              wdt_en,
  input  logic              wdt_dis,
  input  logic              wdt_clr,
  input  logic              irq_en,
  input  logic              irq_dis,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              irq_n
);
  localparam int NRATE = 1 << RATE_W;
  localparam int CNT_W = PRE_W + NRATE - 1;

  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] per_mask;
  logic [CNT_W-1:0] top_bit;
  logic             tb_out;
  logic             wrap;
  logic             tmr_on, wdt_on, irq_on;
  logic             wdt_flag;
  logic [1:0]       wdt_cnt;

  assign per_mask = {CNT_W{1'b1}} >> rate_sel;
  assign top_bit  = per_mask & ~(per_mask >> 1);
  assign tb_out   = |(div_q & top_bit);
  assign wrap     = tick_en && ((div_q & per_mask) == per_mask);

  assign irq_n = ~(irq_on & ((tmr_on & ~tb_out) | wdt_flag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tmr_on <= 1'b0;
      wdt_on <= 1'b0;
      irq_on <= 1'b0;
    end else begin
      if (tmr_clr)      div_q <= '0;
      else if (tick_en) div_q <= div_q + 1'b1;

      if (tmr_dis)      tmr_on <= 1'b0;
      else if (tmr_en)  tmr_on <= 1'b1;

      if (wdt_dis)      wdt_on <= 1'b0;
      else if (wdt_en)  wdt_on <= 1'b1;

      if (irq_dis)      irq_on <= 1'b0;
      else if (irq_en)  irq_on <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_cnt  <= '0;
      wdt_flag <= 1'b0;
    end else if (wdt_dis || wdt_clr) begin
      wdt_cnt  <= '0;
      wdt_flag <= 1'b0;
    end else begin
      if (wdt_on && wrap && !tmr_clr) begin
        wdt_cnt <= wdt_cnt + 1'b1;
        if (&wdt_cnt) wdt_flag <= 1'b1;
      end
      if (irq_dis) wdt_flag <= 1'b0;
    end
  end
endmodule

module tbwd_gen_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             tmr_dis,
  input logic             tmr_clr,
  input logic             wdt_dis,
  input logic             wdt_clr,
  input logic             irq_dis,
  input logic             tmr_on,
  input logic             wdt_on,
  input logic             irq_on,
  input logic             wdt_flag,
  input logic [CNT_W-1:0] div_q,
  input logic             irq_n
);
  AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !tmr_clr |=> div_q == CNT_W'($past(div_q) + 1'b1)); // R2
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !tmr_clr |=> $stable(div_q)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> div_q == '0); // R4
  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_flag) |-> $past(tick_en && wdt_on)); // R5
  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr || wdt_dis || irq_dis) |=> !wdt_flag); // R6
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_on |-> irq_n); // R7
  AST_FLAG_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_flag && irq_on |-> !irq_n); // R8
  AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_dis |=> !tmr_on); // R9
endmodule

bind tbwd_gen tbwd_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tmr_dis(tmr_dis),
  .tmr_clr(tmr_clr), .wdt_dis(wdt_dis), .wdt_clr(wdt_clr), .irq_dis(irq_dis),
  .tmr_on(tmr_on), .wdt_on(wdt_on), .irq_on(irq_on), .wdt_flag(wdt_flag),
  .div_q(div_q), .irq_n(irq_n)
);

// File: tb/tb_tbwd_gen.sv
module tb_tbwd_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic tmr_en = 0, tmr_dis = 0, tmr_clr = 0;
  logic wdt_en = 0, wdt_dis = 0, wdt_clr = 0;
  logic irq_en = 0, irq_dis = 0;
  logic [2:0] rate_sel = 3'd7;
  logic irq_n;

  int checks = 0;
  int errors = 0;

  int unsigned m_div = 0;
  bit m_tmr = 0, m_wdt = 0, m_irq = 0, m_flag = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbwd_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .tmr_en(tmr_en), .tmr_dis(tmr_dis), .tmr_clr(tmr_clr),
    .wdt_en(wdt_en), .wdt_dis(wdt_dis), .wdt_clr(wdt_clr),
    .irq_en(irq_en), .irq_dis(irq_dis), .rate_sel(rate_sel), .irq_n(irq_n)
  );

  function automatic bit wave_of(int unsigned d, int k);
    int unsigned per = 32'd1 << (15 - k);
    return (d % per) >= (per / 2);
  endfunction

  function automatic bit exp_irq_n();
    return !(m_irq && ((m_tmr && !wave_of(m_div, rate_sel)) || m_flag));
  endfunction

  task automatic model_step();
    int unsigned per = 32'd1 << (15 - rate_sel);
    bit completes = tick_en && ((m_div % per) == per - 1);
    bit old_wdt = m_wdt;
    if (wdt_dis || wdt_clr) begin
      m_cnt = 0; m_flag = 0;
    end else begin
      if (old_wdt && completes && !tmr_clr) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 4) begin m_flag = 1; m_cnt = 0; end
      end
      if (irq_dis) m_flag = 0;
    end
    if (tmr_clr) m_div = 0;
    else if (tick_en) m_div = (m_div + 1) % 32768;
    if (tmr_dis) m_tmr = 0; else if (tmr_en) m_tmr = 1;
    if (wdt_dis) m_wdt = 0; else if (wdt_en) m_wdt = 1;
    if (irq_dis) m_irq = 0; else if (irq_en) m_irq = 1;
  endtask

  task automatic check(string tag, bit exp);
    checks++;
    if (irq_n !== exp) begin
      errors++;
      $display("FAIL %s: irq_n=%0b expected %0b at %0t", tag, irq_n, exp, $time);
    end
  endtask

  task automatic clear_pulses();
    {tmr_en, tmr_dis, tmr_clr, wdt_en, wdt_dis, wdt_clr, irq_en, irq_dis} = '0;
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    clear_pulses();
    check(tag, exp_irq_n());
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b1);
    rst_n = 1'b1;
    tick_en = 1'b1;
    run(600, "R1");
    check("R1", 1'b1);

    // R3/R4: fastest rate, clear with coincident tick
    rate_sel = 3'd7; tmr_clr = 1; tmr_en = 1; irq_en = 1;
    cyc("R4");
    check("R4", 1'b0);
    run(127, "R3");
    check("R3", 1'b0);
    cyc("R3");
    check("R3", 1'b1);
    run(200, "R3");

    // R2: ticks stopped, level frozen
    tick_en = 0;
    run(400, "R2");
    tick_en = 1;

    // R3: slowest rate full period
    rate_sel = 3'd0; tmr_clr = 1;
    cyc("R3");
    run(16383, "R3");
    check("R3", 1'b0);
    cyc("R3");
    check("R3", 1'b1);
    run(16390, "R3");

    // R5: watchdog alone at 128 Hz
    rate_sel = 3'd7; tmr_dis = 1; tmr_clr = 1; wdt_en = 1; wdt_clr = 1;
    cyc("R5");
    run(1022, "R5");
    check("R5", 1'b1);
    run(2, "R5");
    check("R5", 1'b0);

    // R6: flag sticks, then clear
    run(700, "R6");
    check("R6", 1'b0);
    // R10: timer clear leaves the flag alone
    tmr_clr = 1;
    cyc("R10");
    check("R10", 1'b0);
    wdt_clr = 1;
    cyc("R6");
    check("R6", 1'b1);

    // R7: interrupt disable drops flag and blocks output
    run(1100, "R5");
    check("R5", 1'b0);
    irq_dis = 1;
    cyc("R7");
    check("R7", 1'b1);
    irq_en = 1;
    cyc("R7");
    check("R7", 1'b1);

    // R8: both sources, time-base low phase visible with no flag
    tmr_en = 1; wdt_clr = 1; tmr_clr = 1;
    cyc("R8");
    check("R8", 1'b0);
    run(200, "R8");

    // R9: same-cycle enable/disable
    tmr_en = 1; tmr_dis = 1; irq_en = 1; irq_dis = 1;
    cyc("R9");
    check("R9", 1'b1);
    irq_en = 1; tmr_clr = 1;
    cyc("R9");
    check("R9", 1'b1);
    // R10: watchdog clear leaves divider phase
    tmr_en = 1;
    cyc("R10");
    run(60, "R10");
    wdt_clr = 1;
    run(200, "R10");

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 90000; i++) begin
      tick_en = ($urandom % 10) != 0;
      tmr_en  = ($urandom % 1500) == 0;
      tmr_dis = ($urandom % 3000) == 0;
      tmr_clr = ($urandom % 4000) == 0;
      wdt_en  = ($urandom % 1500) == 0;
      wdt_dis = ($urandom % 5000) == 0;
      wdt_clr = ($urandom % 4000) == 0;
      irq_en  = ($urandom % 1500) == 0;
      irq_dis = ($urandom % 5000) == 0;
      if (($urandom % 3000) == 0) rate_sel = 3'(4 + ($urandom % 4));
      cyc("R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule